// File: doc/BRIEF.md
# Nine-bit SPI panel command engine

This block is a serial master for display controllers that take 9-bit words on a four-wire serial bus. The ninth bit, sent first, tells the panel whether the remaining eight bits are a command or a parameter. Upstream logic hands the block one word at a time over a valid/ready handshake. Each word carries a flag that says whether it is a command, and a flag that marks the last word of the transaction. The block shifts each word out MSB first in SPI mode 0, and wraps every word in its own chip-select frame.

A second entry point runs the panel identification read. It is a fixed series of three frames: the 9-bit read-ID command 0x04, a 9-bit dummy read that gives the extra turnaround clock, and an 8-bit read. The byte captured in the last frame is presented on `id_byte`. The block holds no initialisation tables and inserts no millisecond delays; the surrounding logic sequences the commands and the waits.

The reset input `rst_n` is asynchronous and active low. Its release must already be synchronous to `clk`.

Top module: `panel_cmd_spi`

## Requirements
- R1: Each frame carries 9 bits MSB first. Bit 8 is 0 for a command word and 1 for a parameter word, and bits 7..0 hold `in_data`.
- R2: The serial clock idles low and rises only while `spi_cs_n` is low. `spi_mosi` changes only while `spi_sck` is low. `spi_miso` is sampled in the cycle where `spi_sck` rises.
- R3: `spi_sck` stays low for HALF_DIV clock cycles and then high for HALF_DIV cycles, once for each bit.
- R4: `spi_cs_n` goes low in the first cycle after a word is accepted. It stays low for HALF_DIV cycles after the last falling edge of `spi_sck`, then stays high for 2*HALF_DIV cycles before the next frame can begin.
- R5: `in_ready` is high only when the block is idle, or waiting between words of a transaction with `spi_cs_n` high. A word is taken on a cycle with `in_valid` and `in_ready` both high, and a word with `in_last` set closes the transaction.
- R6: `busy` rises in the cycle after a transaction starts and falls when the high gap after its last frame ends. `done` is then high for exactly one cycle, and it is the first cycle with `busy` low. After reset, `busy` and `done` are low, `spi_cs_n` is high and `spi_sck` is low.
- R7: A pulse on `id_start` runs three frames with one idle cycle before each: a 9-bit write of 0x004, a 9-bit dummy read, and an 8-bit read. `spi_mosi` is low in both read frames.
- R8: `id_byte` takes the 8 bits sampled in the 8-bit frame, first sample in bit 7, in the same cycle that `done` rises. Bits sampled in the dummy frame have no effect, and `id_byte` holds its value at all other times.
- R9: `id_start` has an effect only while the block is idle with `in_valid` low. If both arrive together, the word is taken; while busy, `id_start` changes nothing on the bus.
- R10: With default parameters, a 50 MHz clock gives a 1 MHz serial clock (HALF_DIV = 25).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block can take a word |
| in_is_cmd | input | 1 | 1: command word, 0: parameter word |
| in_last | input | 1 | Word closes the transaction |
| in_data | input | 8 | Word payload |
| id_start | input | 1 | Start the identification read |
| id_byte | output | 8 | Last identification byte read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select, one frame per word |
| spi_mosi | output | 1 | Serial data to the panel |
| spi_miso | input | 1 | Serial data from the panel |

## Verification
The main instance is built with HALF_DIV = 2. This keeps a 9-bit frame at 42 cycles, so single commands, multi-parameter streams, back-to-back words and both identification reads all fit in a short run. Every cycle of that run is compared against a behavioural waveform model. A second instance keeps the default parameters, and its serial-clock high time is measured to confirm the 1 MHz division from a 50 MHz clock. The bench's panel model drives different bit patterns in the dummy and data frames, so a capture taken from the wrong frame or at the wrong edge shows up in `id_byte`.

// File: rtl/panel_spi_pkg.sv
package panel_spi_pkg;

  localparam int WORD_W = 9;

  typedef enum logic [2:0] {
    SH_IDLE,
    SH_LOW,
    SH_HIGH,
    SH_TAIL,
    SH_GAP
  } sh_state_t;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_WORD,
    TX_WAIT,
    TX_ID
  } seq_state_t;

endpackage

// File: rtl/panel_spi_shifter.sv
module panel_spi_shifter
  import panel_spi_pkg::*;
#(
  parameter int HALF_DIV = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              len9,
  input  logic              miso,
  output logic              idle,
  output logic              word_end,
  output logic [7:0]        rx_byte,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi
);

  localparam int CW = $clog2(2 * HALF_DIV + 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] GAP_LAST  = CW'(2 * HALF_DIV - 1);

  sh_state_t         st_q, st_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [3:0]        bits_q, bits_n;
  logic [WORD_W-1:0] sh_q, sh_n;
  logic [7:0]        rx_q, rx_n;
  logic              sck_q, sck_n;
  logic              cs_q, cs_n_n;
  logic              half_end, gap_end;

  assign half_end = (cnt_q == HALF_LAST);
  assign gap_end  = (cnt_q == GAP_LAST);

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    bits_n   = bits_q;
    sh_n     = sh_q;
    rx_n     = rx_q;
    sck_n    = sck_q;
    cs_n_n   = cs_q;
    word_end = 1'b0;
    unique case (st_q)
      SH_IDLE: begin
        if (start) begin
          st_n   = SH_LOW;
          cnt_n  = '0;
          bits_n = len9 ? 4'd8 : 4'd7;
          sh_n   = tx_word;
          cs_n_n = 1'b0;
        end
      end
      SH_LOW: begin
        if (half_end) begin
          st_n  = SH_HIGH;
          cnt_n = '0;
          sck_n = 1'b1;
          rx_n  = {rx_q[6:0], miso};
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
      SH_HIGH: begin
        if (half_end) begin
          sck_n = 1'b0;
          cnt_n = '0;
          if (bits_q == 4'd0) begin
            st_n = SH_TAIL;
          end else begin
            st_n   = SH_LOW;
            bits_n = bits_q - 4'd1;
            sh_n   = {sh_q[WORD_W-2:0], 1'b0};
          end
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
      SH_TAIL: begin
        if (half_end) begin
          st_n   = SH_GAP;
          cnt_n  = '0;
          cs_n_n = 1'b1;
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
      SH_GAP: begin
        if (gap_end) begin
          st_n     = SH_IDLE;
          word_end = 1'b1;
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
      default: st_n = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      cnt_q  <= '0;
      bits_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      bits_q <= bits_n;
      sh_q   <= sh_n;
      rx_q   <= rx_n;
      sck_q  <= sck_n;
      cs_q   <= cs_n_n;
    end
  end

  assign idle    = (st_q == SH_IDLE);
  assign rx_byte = rx_q;
  assign sck     = sck_q;
  assign cs_n    = cs_q;
  assign mosi    = sh_q[WORD_W-1];

endmodule

// File: rtl/panel_spi_seq.sv
module panel_spi_seq
  import panel_spi_pkg::*;
#(
  parameter logic [7:0] ID_CMD = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_is_cmd,
  input  logic              in_last,
  input  logic [7:0]        in_data,
  input  logic              id_start,
  input  logic              sh_idle,
  input  logic              word_end,
  input  logic [7:0]        rx_byte,
  output logic              in_ready,
  output logic              sh_start,
  output logic [WORD_W-1:0] sh_word,
  output logic              sh_len9,
  output logic              busy,
  output logic              done,
  output logic [7:0]        id_byte
);

  seq_state_t q_q, q_n;
  logic [1:0] ph_q, ph_n;
  logic       last_q, last_n;
  logic       done_q, done_n;
  logic [7:0] id_q, id_n;
  logic       fire, id_go;

  assign in_ready = (q_q == TX_IDLE) || (q_q == TX_WAIT);
  assign fire     = in_valid && in_ready;
  assign id_go    = (q_q == TX_ID) && sh_idle;
  assign sh_start = fire || id_go;
  assign sh_len9  = fire || (ph_q != 2'd2);

  always_comb begin
    if (fire)
      sh_word = {~in_is_cmd, in_data};
    else if (ph_q == 2'd0)
      sh_word = {1'b0, ID_CMD};
    else
      sh_word = '0;
  end

  always_comb begin
    q_n    = q_q;
    ph_n   = ph_q;
    last_n = last_q;
    done_n = 1'b0;
    id_n   = id_q;
    unique case (q_q)
      TX_IDLE: begin
        if (fire) begin
          q_n    = TX_WORD;
          last_n = in_last;
        end else if (id_start) begin
          q_n  = TX_ID;
          ph_n = 2'd0;
        end
      end
      TX_WORD: begin
        if (word_end) begin
          if (last_q) begin
            q_n    = TX_IDLE;
            done_n = 1'b1;
          end else begin
            q_n = TX_WAIT;
          end
        end
      end
      TX_WAIT: begin
        if (fire) begin
          q_n    = TX_WORD;
          last_n = in_last;
        end
      end
      TX_ID: begin
        if (word_end) begin
          if (ph_q == 2'd2) begin
            q_n    = TX_IDLE;
            done_n = 1'b1;
            id_n   = rx_byte;
          end else begin
            ph_n = ph_q + 2'd1;
          end
        end
      end
      default: q_n = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= TX_IDLE;
      ph_q   <= '0;
      last_q <= 1'b0;
      done_q <= 1'b0;
      id_q   <= '0;
    end else begin
      q_q    <= q_n;
      ph_q   <= ph_n;
      last_q <= last_n;
      done_q <= done_n;
      id_q   <= id_n;
    end
  end

  assign busy    = (q_q != TX_IDLE);
  assign done    = done_q;
  assign id_byte = id_q;

endmodule

// File: rtl/panel_cmd_spi.sv
module panel_cmd_spi
  import panel_spi_pkg::*;
#(
  parameter int SYS_HZ   = 50_000_000,
  parameter int SCK_HZ   = 1_000_000,
  parameter int HALF_DIV = SYS_HZ / (2 * SCK_HZ)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_is_cmd,
  input  logic       in_last,
  input  logic [7:0] in_data,
  input  logic       id_start,
  output logic [7:0] id_byte,
  output logic       busy,
  output logic       done,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);

  logic              sh_start, sh_len9, sh_idle, sh_end;
  logic [WORD_W-1:0] sh_word;
  logic [7:0]        sh_rx;

  panel_spi_seq #(.ID_CMD(8'h04)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_is_cmd(in_is_cmd),
    .in_last  (in_last),
    .in_data  (in_data),
    .id_start (id_start),
    .sh_idle  (sh_idle),
    .word_end (sh_end),
    .rx_byte  (sh_rx),
    .in_ready (in_ready),
    .sh_start (sh_start),
    .sh_word  (sh_word),
    .sh_len9  (sh_len9),
    .busy     (busy),
    .done     (done),
    .id_byte  (id_byte)
  );

  panel_spi_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sh_start),
    .tx_word (sh_word),
    .len9    (sh_len9),
    .miso    (spi_miso),
    .idle    (sh_idle),
    .word_end(sh_end),
    .rx_byte (sh_rx),
    .sck     (spi_sck),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi)
  );

endmodule

// File: rtl/panel_cmd_spi_chk.sv
module panel_cmd_spi_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_sck,
  input logic       spi_cs_n,
  input logic       spi_mosi,
  input logic       busy,
  input logic       done,
  input logic       in_ready,
  input logic [7:0] id_byte
);

  // R2
  sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n);

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  // R4
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> !spi_sck);

  // R5
  ready_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> spi_cs_n);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(id_byte));

endmodule

bind panel_cmd_spi panel_cmd_spi_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .spi_sck (spi_sck),
  .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi),
  .busy    (busy),
  .done    (done),
  .in_ready(in_ready),
  .id_byte (id_byte)
);

// File: tb/panel_cmd_spi_tb.sv
module panel_cmd_spi_tb;

  localparam int H = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_is_cmd, in_last, id_start, spi_miso;
  logic [7:0] in_data;
  logic       in_ready, busy, done, spi_sck, spi_cs_n, spi_mosi;
  logic [7:0] id_byte;

  logic       d_valid, d_ready, d_busy, d_done, d_sck, d_cs_n, d_mosi;
  logic [7:0] d_id;

  always #10 clk = ~clk;

  panel_cmd_spi #(.HALF_DIV(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_cmd(in_is_cmd), .in_last(in_last), .in_data(in_data),
    .id_start(id_start), .id_byte(id_byte), .busy(busy), .done(done),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  panel_cmd_spi u_def (
    .clk(clk), .rst_n(rst_n), .in_valid(d_valid), .in_ready(d_ready),
    .in_is_cmd(1'b1), .in_last(1'b1), .in_data(8'h11),
    .id_start(1'b0), .id_byte(d_id), .busy(d_busy), .done(d_done),
    .spi_sck(d_sck), .spi_cs_n(d_cs_n), .spi_mosi(d_mosi),
    .spi_miso(1'b0)
  );

  int vectors = 0;
  int miscompares = 0;
  bit chk_en = 1'b0;

  // expected entry: {cs_n, sck, mosi, mosi_care, busy, done, ready}
  logic [6:0] expq[$];
  logic [8:0] wq[$];

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic check(input string req, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic push_ent(input logic cs, sck, mo, care, bz, dn, rdy);
    expq.push_back({cs, sck, mo, care, bz, dn, rdy});
  endtask

  // one frame: nb bits MSB first from w[8], tail, gap
  task automatic push_frame(input logic [8:0] w, input int nb);
    for (int b = 0; b < nb; b++) begin
      for (int k = 0; k < H; k++) push_ent(1'b0, 1'b0, w[8-b], 1'b1, 1'b1, 1'b0, 1'b0);
      for (int k = 0; k < H; k++) push_ent(1'b0, 1'b1, w[8-b], 1'b1, 1'b1, 1'b0, 1'b0);
    end
    for (int k = 0; k < H; k++) push_ent(1'b0, 1'b0, w[9-nb], 1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 2*H; k++) push_ent(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  // per-cycle comparison against the behavioural model
  always @(posedge clk) begin
    #5;
    if (chk_en) begin
      logic [6:0] e;
      e = (expq.size() != 0) ? expq.pop_front() : 7'b1000001;
      check("R4 cs_n", spi_cs_n, e[6]);
      check("R2/R3 sck", spi_sck, e[5]);
      if (e[3]) check("R1/R7 mosi", spi_mosi, e[4]);
      check("R6 busy", busy, e[2]);
      check("R6 done", done, e[1]);
      check("R5 in_ready", in_ready, e[0]);
    end
  end

  // panel model: shifts data out on falling sck, one value per frame
  int         slv_frame = 0;
  logic [7:0] slv_id = 8'h00;
  logic [8:0] slv_sr = 9'h000;
  always @(negedge spi_cs_n) begin
    slv_frame++;
    slv_sr   = (slv_frame == 3) ? {slv_id, 1'b1} : {~slv_id, 1'b0};
    spi_miso = slv_sr[8];
  end
  always @(negedge spi_sck) begin
    slv_sr   = {slv_sr[7:0], 1'b0};
    spi_miso = slv_sr[8];
  end

  task automatic run_txn();
    int n;
    n = wq.size();
    for (int i = 0; i < n; i++) begin
      push_frame(wq[i], 9);
      if (i < n - 1) push_ent(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
      else           push_ent(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    end
    for (int i = 0; i < n; i++) begin
      in_valid  = 1'b1;
      in_is_cmd = ~wq[i][8];
      in_data   = wq[i][7:0];
      in_last   = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    wq.delete();
  endtask

  task automatic wait_empty();
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // R7 frame sequence and R8 capture
  task automatic run_id(input logic [7:0] v);
    slv_frame = 0;
    slv_id    = v;
    push_ent(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    push_frame(9'h004, 9);
    push_ent(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    push_frame(9'h000, 9);
    push_ent(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    push_frame(9'h000, 8);
    push_ent(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    id_start = 1'b1;
    @(negedge clk);
    id_start = 1'b0;
    while (expq.size() != 0) @(negedge clk);
    check("R8 id_byte", id_byte, v);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin : main
    int hi;
    rst_n = 1'b0; in_valid = 1'b0; in_is_cmd = 1'b0; in_last = 1'b0;
    in_data = 8'h00; id_start = 1'b0; spi_miso = 1'b0; d_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R6 reset state
    check("R6 reset busy", busy, 0);
    check("R6 reset done", done, 0);
    check("R6 reset cs_n", spi_cs_n, 1);
    check("R6 reset sck", spi_sck, 0);
    rst_n  = 1'b1;
    chk_en = 1'b1;
    repeat (2) @(negedge clk);

    // R1 lone command, no parameters
    wq.push_back(9'h011);
    run_txn(); wait_empty();

    // R1 R5 command with four parameters back to back
    wq.push_back(9'h0B6); wq.push_back(9'h122); wq.push_back(9'h1E2);
    wq.push_back(9'h1FF); wq.push_back(9'h104);
    run_txn(); wait_empty();

    // R9 id_start while busy has no effect on the bus
    wq.push_back(9'h036); wq.push_back(9'h108);
    fork
      run_txn();
      begin repeat (10) @(negedge clk); id_start = 1'b1; @(negedge clk); id_start = 1'b0; end
    join
    wait_empty();

    // R7 R8 identification reads with different bytes
    run_id(8'h80);
    run_id(8'h5A);
    run_id(8'hFF);

    // R9 word and id_start together: the word is taken
    wq.push_back(9'h029);
    fork
      run_txn();
      begin id_start = 1'b1; @(negedge clk); id_start = 1'b0; end
    join
    wait_empty();
    check("R8 id_byte kept", id_byte, 8'hFF);

    // R1 parameter-only stream, all-zero and all-one payloads
    wq.push_back(9'h100); wq.push_back(9'h1FF); wq.push_back(9'h000);
    run_txn(); wait_empty();

    // R10 default division: sck high for 25 cycles
    d_valid = 1'b1;
    @(negedge clk);
    d_valid = 1'b0;
    wait (d_sck == 1'b1);
    @(negedge clk);
    hi = 0;
    while (d_sck) begin hi++; @(negedge clk); end
    check("R10 default sck high cycles", hi, 25);
    wait (d_done == 1'b1);
    @(negedge clk);
    finish_run();
  end

endmodule